// File: doc/BRIEF.md
# Sharer Directory Entry with Pointer and Region Modes

This block keeps the sharer record for one memory line in a 16-node distributed shared memory. While few nodes share the line, it records each sharer exactly as a node number in a small set of pointer slots. When one more distinct sharer arrives than there are slots, the entry drops the exact pointers and keeps a region vector instead. Each bit of that vector stands for a fixed group of neighbouring nodes.

When a node asks to write, the block works out every node that must lose its copy. It sends those node numbers out one per clock cycle in ascending order, leaves out the writer itself, and then raises a completion flag. When the write completes, the writer is the only recorded sharer. A clear input empties the entry. Sending the messages and collecting acknowledgements are the job of the logic around this block.

Top module: `dirent_ptr_coarse`

## Requirements
- R1: After reset the entry is empty: `inv_vld` and `done` are low, and a first write produces no targets and raises `done` in the cycle after it is accepted.
- R2: In pointer mode, up to two distinct added nodes are recorded exactly, and a write invalidates exactly those nodes.
- R3: Adding a node that is already recorded changes nothing. It takes no pointer slot and does not cause overflow.
- R4: When a third distinct node is added while both slots are full, the entry switches to region mode. The region bit of every recorded node and of the new node is set, where bit k covers nodes 4k to 4k+3. A later write invalidates every node of every marked region.
- R5: In region mode, an added node sets the bit of its region (bit = node id divided by 4).
- R6: Targets appear one per cycle in ascending node order. The first target is visible in the cycle after the write is accepted. `done` is a one-cycle pulse in the cycle after the last target, or in the cycle after acceptance when there are no targets.
- R7: The writer's own id is never sent as a target.
- R8: After `done`, the entry is back in pointer mode with only the writer recorded, so the next write by another node invalidates only the previous writer.
- R9: With the block idle, `clr` empties the entry, and a following write produces no targets.
- R10: While a write is being processed, add and write requests are ignored and the target stream carries on unchanged.
- R11: `clr` during processing stops the stream at once. No `done` follows, and the entry is left empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| add_vld | input | 1 | Record a new sharer |
| add_id | input | 4 | Node id of the new sharer |
| wr_vld | input | 1 | Write request; starts invalidation |
| wr_id | input | 4 | Node id of the writer |
| clr | input | 1 | Empty the entry; highest priority |
| inv_vld | output | 1 | A target node id is present |
| inv_id | output | 4 | Node id to invalidate |
| done | output | 1 | One-cycle pulse ending an invalidation run |

## Verification
A wrong internal state in this block, such as a duplicated pointer, a missed overflow, a wrong region bit or a stale owner, stays hidden until the next write. That write then shows it as a wrong set of target ids. The error appears within the sharer count plus one cycles after the write is accepted. An ordering or skip fault shows as a non-ascending stream, or as the writer's id appearing as a target. A timing fault shows as `done` arriving earlier or later than one cycle after the last target. Each scenario therefore ends with a write, and the bench compares the target set, the order and the cycle of `done` against the expected values.

// File: rtl/dirent_pkg.sv
package dirent_pkg;
   localparam int DIR_NODES  = 16;
   localparam int DIR_PTRS   = 2;
   localparam int DIR_REGION = 4;
endpackage

// File: rtl/dirent_store.sv
module dirent_store #(
   parameter int NODES  = dirent_pkg::DIR_NODES,
   parameter int NPTR   = dirent_pkg::DIR_PTRS,
   parameter int REGION = dirent_pkg::DIR_REGION,
   localparam int ID_W  = $clog2(NODES),
   localparam int RG_W  = $clog2(REGION),
   localparam int NREG  = NODES / REGION,
   localparam int PI_W  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       add_en,
   input  logic [ID_W-1:0]            add_id,
   input  logic                       set_own,
   input  logic [ID_W-1:0]            own_id,
   output logic                       ovf,
   output logic [NPTR-1:0]            ptr_v,
   output logic [NPTR-1:0][ID_W-1:0]  ptr_id,
   output logic [NREG-1:0]            coarse
);
   logic            hit;
   logic            free_ok;
   logic [PI_W-1:0] free_idx;
   logic [NREG-1:0] ptr_rmask;
   logic [NREG-1:0] add_rbit;

   always_comb begin
      hit       = 1'b0;
      free_ok   = 1'b0;
      free_idx  = '0;
      ptr_rmask = '0;
      add_rbit  = '0;
      add_rbit[add_id[ID_W-1:RG_W]] = 1'b1;
      for (int i = NPTR - 1; i >= 0; i--) begin
         if (ptr_v[i] && ptr_id[i] == add_id) hit = 1'b1;
         if (!ptr_v[i]) begin
            free_ok  = 1'b1;
            free_idx = PI_W'(i);
         end
         if (ptr_v[i]) ptr_rmask[ptr_id[i][ID_W-1:RG_W]] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ovf    <= 1'b0;
         ptr_v  <= '0;
         ptr_id <= '0;
         coarse <= '0;
      end else if (set_own) begin
         ovf       <= 1'b0;
         ptr_v     <= '0;
         ptr_v[0]  <= 1'b1;
         ptr_id[0] <= own_id;
         coarse    <= '0;
      end else if (add_en) begin
         if (ovf) begin
            coarse <= coarse | add_rbit;
         end else if (!hit) begin
            if (free_ok) begin
               ptr_v[free_idx]  <= 1'b1;
               ptr_id[free_idx] <= add_id;
            end else begin
               ovf    <= 1'b1;
               ptr_v  <= '0;
               coarse <= ptr_rmask | add_rbit;
            end
         end
      end
   end

   for (genvar a = 0; a < NPTR; a++) begin : g_pair_a
      for (genvar b = a + 1; b < NPTR; b++) begin : g_pair_b
         p_distinct_ptrs_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ovf && ptr_v[a] && ptr_v[b]) |-> (ptr_id[a] != ptr_id[b]));
      end
   end

   p_coarse_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (coarse != '0));

   p_owner_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_own && !clr) |=> (!ovf && $countones(ptr_v) == 1 && ptr_id[0] == $past(own_id)));
endmodule

// File: rtl/dirent_expand.sv
module dirent_expand #(
   parameter int NODES  = dirent_pkg::DIR_NODES,
   parameter int NPTR   = dirent_pkg::DIR_PTRS,
   parameter int REGION = dirent_pkg::DIR_REGION,
   localparam int ID_W  = $clog2(NODES),
   localparam int NREG  = NODES / REGION
) (
   input  logic                       ovf,
   input  logic [NPTR-1:0]            ptr_v,
   input  logic [NPTR-1:0][ID_W-1:0]  ptr_id,
   input  logic [NREG-1:0]            coarse,
   input  logic [ID_W-1:0]            writer,
   output logic [NODES-1:0]           tgt
);
   for (genvar n = 0; n < NODES; n++) begin : g_node
      logic named;
      always_comb begin
         named = 1'b0;
         for (int i = 0; i < NPTR; i++)
            if (ptr_v[i] && ptr_id[i] == ID_W'(n)) named = 1'b1;
      end
      assign tgt[n] = (ovf ? coarse[n / REGION] : named) && (writer != ID_W'(n));
   end
endmodule

// File: rtl/dirent_scan.sv
module dirent_scan #(
   parameter int NODES = dirent_pkg::DIR_NODES,
   localparam int ID_W = $clog2(NODES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  logic [NODES-1:0] start_mask,
   input  logic [ID_W-1:0]  start_wid,
   output logic             busy,
   output logic             inv_vld,
   output logic [ID_W-1:0]  inv_id,
   output logic             done,
   output logic [ID_W-1:0]  own_id
);
   logic [NODES-1:0] mask;
   logic [ID_W-1:0]  low;

   always_comb begin
      low = '0;
      for (int n = NODES - 1; n >= 0; n--)
         if (mask[n]) low = ID_W'(n);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         busy   <= 1'b0;
         mask   <= '0;
         own_id <= '0;
      end else if (start && !busy) begin
         busy   <= 1'b1;
         mask   <= start_mask;
         own_id <= start_wid;
      end else if (busy) begin
         if (mask == '0) busy <= 1'b0;
         else            mask[low] <= 1'b0;
      end
   end

   assign inv_vld = busy && (mask != '0);
   assign inv_id  = low;
   assign done    = busy && (mask == '0);

   p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_vld && $past(inv_vld) && !$past(clr) && !$past(start && !busy)) |-> (inv_id > $past(inv_id)));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_skip_writer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inv_vld |-> (inv_id != own_id));
endmodule

// File: rtl/dirent_ptr_coarse.sv
module dirent_ptr_coarse #(
   parameter int NODES  = dirent_pkg::DIR_NODES,
   parameter int NPTR   = dirent_pkg::DIR_PTRS,
   parameter int REGION = dirent_pkg::DIR_REGION,
   localparam int ID_W  = $clog2(NODES),
   localparam int NREG  = NODES / REGION
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            add_vld,
   input  logic [ID_W-1:0] add_id,
   input  logic            wr_vld,
   input  logic [ID_W-1:0] wr_id,
   input  logic            clr,
   output logic            inv_vld,
   output logic [ID_W-1:0] inv_id,
   output logic            done
);
   if ((1 << ID_W) != NODES) begin : g_bad_nodes
      $error("NODES must be a power of two");
   end
   if (REGION < 1 || REGION >= NODES || (1 << $clog2(REGION)) != REGION) begin : g_bad_region
      $error("REGION must be a power of two below NODES");
   end
   if (NPTR < 1 || NPTR >= NODES) begin : g_bad_ptrs
      $error("NPTR must be between 1 and NODES-1");
   end

   logic                      busy;
   logic                      ovf;
   logic [NPTR-1:0]           ptr_v;
   logic [NPTR-1:0][ID_W-1:0] ptr_id;
   logic [NREG-1:0]           coarse;
   logic [NODES-1:0]          tgt;
   logic [ID_W-1:0]           own_id;
   logic                      start;
   logic                      add_en;

   assign start  = wr_vld && !busy && !clr;
   assign add_en = add_vld && !busy && !wr_vld;

   dirent_store #(.NODES(NODES), .NPTR(NPTR), .REGION(REGION)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(clr), .add_en(add_en), .add_id(add_id),
      .set_own(done), .own_id(own_id), .ovf(ovf), .ptr_v(ptr_v),
      .ptr_id(ptr_id), .coarse(coarse));

   dirent_expand #(.NODES(NODES), .NPTR(NPTR), .REGION(REGION)) u_expand (
      .ovf(ovf), .ptr_v(ptr_v), .ptr_id(ptr_id), .coarse(coarse),
      .writer(wr_id), .tgt(tgt));

   dirent_scan #(.NODES(NODES)) u_scan (
      .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .start_mask(tgt),
      .start_wid(wr_id), .busy(busy), .inv_vld(inv_vld), .inv_id(inv_id),
      .done(done), .own_id(own_id));

   p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && !clr) |=> $stable(own_id));

   p_clr_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!inv_vld && !done));
endmodule

// File: tb/sim_dirent_ptr_coarse.sv
`timescale 1ns/1ps
module sim_dirent_ptr_coarse;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       add_vld = 1'b0;
   logic [3:0] add_id = '0;
   logic       wr_vld = 1'b0;
   logic [3:0] wr_id = '0;
   logic       clr = 1'b0;
   logic       inv_vld;
   logic [3:0] inv_id;
   logic       done;
   int         n_chk = 0;
   int         n_bad = 0;

   always #5 clk = ~clk;

   dirent_ptr_coarse u0 (
      .clk(clk), .rst_n(rst_n), .add_vld(add_vld), .add_id(add_id),
      .wr_vld(wr_vld), .wr_id(wr_id), .clr(clr), .inv_vld(inv_vld),
      .inv_id(inv_id), .done(done));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic add(input int id);
      @(negedge clk); add_vld = 1'b1; add_id = 4'(id);
      @(negedge clk); add_vld = 1'b0;
   endtask

   task automatic do_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   // issue a write and check target set, order and done timing
   task automatic run_write(input int wid, input logic [15:0] exp, input string req);
      logic [15:0] got = '0;
      int          cyc = 1;
      int          last = -1;
      bit          order_ok = 1'b1;
      @(negedge clk); wr_vld = 1'b1; wr_id = 4'(wid);
      @(negedge clk); wr_vld = 1'b0;
      while (!done && cyc < 40) begin
         if (inv_vld) begin
            if (int'(inv_id) <= last) order_ok = 1'b0;
            got[inv_id] = 1'b1;
            last = int'(inv_id);
         end
         @(negedge clk); cyc++;
      end
      check(got == exp, {req, " target set"}, got, exp);
      check(order_ok, {req, " R6 ascending order"}, order_ok, 1);
      check(done && cyc == $countones(exp) + 1, {req, " R6 done cycle"}, cyc, $countones(exp) + 1);
   endtask

   task automatic t_reset();
      check(!inv_vld && !done, "R1 reset outputs", {inv_vld, done}, 0);
      run_write(5, 16'h0000, "R1");
   endtask

   task automatic t_pointers();
      do_clr(); add(3); add(9);
      run_write(0, 16'h0208, "R2");
   endtask

   task automatic t_dup();
      do_clr(); add(7); add(7); add(7); add(2);
      run_write(15, 16'h0084, "R3");
   endtask

   task automatic t_skip();
      do_clr(); add(4); add(6);
      run_write(4, 16'h0040, "R7");
   endtask

   task automatic t_coarse();
      do_clr(); add(1); add(6); add(13);
      run_write(5, 16'hF0DF, "R4");
      run_write(10, 16'h0020, "R8");
   endtask

   task automatic t_coarse_add();
      do_clr(); add(0); add(1); add(2); add(9);
      run_write(3, 16'h0F07, "R5");
   endtask

   task automatic t_clear();
      add(3); do_clr();
      run_write(1, 16'h0000, "R9");
   endtask

   task automatic t_busy();
      do_clr(); add(2); add(8);
      @(negedge clk); wr_vld = 1'b1; wr_id = 4'd0;
      @(negedge clk);
      check(inv_vld && inv_id == 4'd2, "R10 first target while busy", inv_id, 2);
      wr_vld = 1'b1; wr_id = 4'd4; add_vld = 1'b1; add_id = 4'd11;
      @(negedge clk); wr_vld = 1'b0; add_vld = 1'b0;
      check(inv_vld && inv_id == 4'd8, "R10 second target", inv_id, 8);
      @(negedge clk);
      check(done && !inv_vld, "R10 done after stream", done, 1);
      run_write(1, 16'h0001, "R10");
   endtask

   task automatic t_clr_abort();
      do_clr(); add(2); add(8);
      @(negedge clk); wr_vld = 1'b1; wr_id = 4'd0;
      @(negedge clk); wr_vld = 1'b0; clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      check(!inv_vld && !done, "R11 stream stopped", {inv_vld, done}, 0);
      @(negedge clk);
      check(!inv_vld && !done, "R11 no late done", {inv_vld, done}, 0);
      run_write(1, 16'h0000, "R11");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_pointers();
      t_dup();
      t_skip();
      t_coarse();
      t_coarse_add();
      t_clear();
      t_busy();
      t_clr_abort();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule